// File: doc/BRIEF.md
# Display Memory Write Port

This block is the host-facing store of a four-digit dot-matrix display controller. A processor drives it like a small memory-mapped peripheral. A write strobe commits a 7-bit value when both active-low chip enables are asserted. A target-select line steers each write to one of two places. One is the character store, which holds one 7-bit code per digit. The other is the per-digit attribute store, which holds a cursor flag and a blank-override flag for each digit. Writes to digit 0 of the attribute store also update a global control word: master blank, a 3-bit brightness code and an extended-function disable.

All host signals are sampled in the system clock domain. A write is taken when the strobe rises. The data, address and select used are those sampled on the last clock edge at which the strobe was still low. An active-low clear returns every character to the space code and every flag to zero, whatever the chip enables are doing. All stored contents are presented continuously as outputs for the refresh and blanking logic. Nothing can be read back over the host bus.

Top module: `disp_wr_port`

## Requirements
- R1: A write changes no storage unless `ce_a_n` and `ce_b_n` were both 0 in the clock sample where the strobe was last seen low.
- R2: A write commits only on a low-to-high transition of `wr_n`, and commits once per transition. Storage stays unchanged while `wr_n` is held low. The new value appears after the second rising clock edge that samples `wr_n` high. It uses the address, select and data sampled on the last edge where `wr_n` was low.
- R3: With `sel_char` = 1, `din` is stored as the character of digit `addr`. Digit 0 (rightmost) is `char_flat[6:0]` and digit 3 (leftmost) is `char_flat[27:21]`.
- R4: With `sel_char` = 0, `din[0]` is stored in `cursor_on[addr]` and `din[1]` is stored in `blank_dis[addr]`.
- R5: With `sel_char` = 0 and `addr` = 0, the control word is also loaded: `din[2]` goes to `master_blank`, `din[5:3]` to `bright_code` and `din[6]` to `ext_fn_dis`.
- R6: With `sel_char` = 0 and `addr` not 0, the control word is unchanged. Only that digit's two flags change.
- R7: When `clr_n` is sampled 0 at a clock edge, every character becomes 7'h20 and all cursor, blank-override and control bits become 0, whatever the chip enables are.
- R8: A clear wins over a write. A write whose commit would fall on, or still be in flight at, an edge where `clr_n` is 0 is discarded.
- R9: Digits can be written in any order, and a write to one location leaves every other location unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| clr_n | input | 1 | Active-low clear of all storage |
| wr_n | input | 1 | Write strobe; commit on its rising transition |
| ce_a_n | input | 1 | First active-low chip enable |
| ce_b_n | input | 1 | Second active-low chip enable |
| sel_char | input | 1 | 1 = character store, 0 = attribute/control store |
| addr | input | 2 | Digit index, 0 = rightmost |
| din | input | 7 | Write data |
| char_flat | output | 28 | Character codes, digit i at bits [7i+6:7i] |
| cursor_on | output | 4 | Per-digit cursor flag |
| blank_dis | output | 4 | Per-digit blank-override flag |
| master_blank | output | 1 | Global blank request |
| bright_code | output | 3 | Brightness code, 0 = brightest |
| ext_fn_dis | output | 1 | Extended-function disable |

## Verification
On every cycle, the assertions check the following. Storage holds when no write decodes. The control word holds unless digit 0 of the attribute store is written. A committed character or control write lands with the sampled data. The strobe detector never fires twice in a row. Everything is at its cleared value right after clear releases. The bench scenarios show what a property cannot easily express. They confirm that the value sampled while the strobe was low is the one kept after the data bus changes. They confirm the exact commit latency, and that writes to many digits in mixed order keep all other locations intact. They also confirm that a clear arriving while a write is in flight leaves no trace afterwards.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;

    localparam logic [6:0] SPACE_CODE = 7'h20;

    // bit positions within a write word for the attribute/control target
    localparam int CUR_BIT   = 0;
    localparam int BDIS_BIT  = 1;
    localparam int MBLK_BIT  = 2;
    localparam int BRT_LSB   = 3;
    localparam int BRT_W     = 3;
    localparam int EFD_BIT   = 6;

    typedef struct packed {
        logic             mblk;
        logic [BRT_W-1:0] brt;
        logic             efd;
    } ctrl_t;

endpackage

// File: rtl/disp_wr_sync.sv
module disp_wr_sync #(
    parameter  int NUM_DIG = 4,
    parameter  int DW      = 7,
    localparam int AW      = $clog2(NUM_DIG)
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          wr_n,
    input  logic          ce_a_n,
    input  logic          ce_b_n,
    input  logic          sel_char,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          evt,
    output logic          evt_ce_ok,
    output logic          evt_sel,
    output logic [AW-1:0] evt_addr,
    output logic [DW-1:0] evt_data
);

    typedef struct packed {
        logic          wr_n;
        logic          ce_ok;
        logic          sel;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } smp_t;

    typedef struct packed {
        smp_t s1;
        smp_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    smp_t  idle_c;

    always_comb begin
        idle_c      = '0;
        idle_c.wr_n = 1'b1;
        pipe_d          = pipe_q;
        pipe_d.s1.wr_n  = wr_n;
        pipe_d.s1.ce_ok = ~ce_a_n & ~ce_b_n;
        pipe_d.s1.sel   = sel_char;
        pipe_d.s1.addr  = addr;
        pipe_d.s1.data  = din;
        pipe_d.s2       = pipe_q.s1;
        if (!clr_n) begin
            pipe_d.s1 = idle_c;
            pipe_d.s2 = idle_c;
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    // rising strobe: newest sample high, previous sample low
    assign evt       = pipe_q.s1.wr_n & ~pipe_q.s2.wr_n;
    assign evt_ce_ok = pipe_q.s2.ce_ok;
    assign evt_sel   = pipe_q.s2.sel;
    assign evt_addr  = pipe_q.s2.addr;
    assign evt_data  = pipe_q.s2.data;

    // R2: one commit per strobe transition
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!clr_n)
        evt |=> !evt);

    // R2: a commit needs the strobe seen high after being seen low
    a_r2_needs_rise: assert property (@(posedge clk) disable iff (!clr_n)
        evt |-> $past(wr_n));

endmodule

// File: rtl/disp_wr_decode.sv
module disp_wr_decode #(
    parameter  int NUM_DIG = 4,
    localparam int AW      = $clog2(NUM_DIG)
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               evt,
    input  logic               ce_ok,
    input  logic               sel,
    input  logic [AW-1:0]      addr,
    output logic [NUM_DIG-1:0] char_we,
    output logic [NUM_DIG-1:0] attr_we,
    output logic               ctrl_we
);

    logic go;
    assign go = evt & ce_ok;

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
        logic hit;
        assign hit        = go & (addr == AW'(g));
        assign char_we[g] = hit & sel;
        assign attr_we[g] = hit & ~sel;
    end

    assign ctrl_we = go & ~sel & (addr == '0);

    // R9: one location class per commit
    a_r9_one_target: assert property (@(posedge clk) disable iff (!clr_n)
        $onehot0({char_we, attr_we}));

    // R1: nothing enabled without a strobe event
    a_r1_no_event_no_we: assert property (@(posedge clk) disable iff (!clr_n)
        !evt |-> (char_we == '0 && attr_we == '0 && !ctrl_we));

endmodule

// File: rtl/disp_wr_store.sv
module disp_wr_store
    import disp_wr_pkg::*;
#(
    parameter int NUM_DIG = 4,
    parameter int DW      = 7
) (
    input  logic                  clk,
    input  logic                  clr_n,
    input  logic [NUM_DIG-1:0]    char_we,
    input  logic [NUM_DIG-1:0]    attr_we,
    input  logic                  ctrl_we,
    input  logic [DW-1:0]         data,
    output logic [NUM_DIG*DW-1:0] char_flat,
    output logic [NUM_DIG-1:0]    cursor_on,
    output logic [NUM_DIG-1:0]    blank_dis,
    output ctrl_t                 ctrl
);

    typedef struct packed {
        logic [NUM_DIG-1:0][DW-1:0] chr;
        logic [NUM_DIG-1:0]         cur;
        logic [NUM_DIG-1:0]         bdis;
        ctrl_t                      ctl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_DIG; i++) begin
            if (char_we[i]) begin
                st_d.chr[i] = data;
            end
            if (attr_we[i]) begin
                st_d.cur[i]  = data[CUR_BIT];
                st_d.bdis[i] = data[BDIS_BIT];
            end
        end
        if (ctrl_we) begin
            st_d.ctl.mblk = data[MBLK_BIT];
            st_d.ctl.brt  = data[BRT_LSB +: BRT_W];
            st_d.ctl.efd  = data[EFD_BIT];
        end
        if (!clr_n) begin
            for (int i = 0; i < NUM_DIG; i++) begin
                st_d.chr[i] = DW'(SPACE_CODE);
            end
            st_d.cur  = '0;
            st_d.bdis = '0;
            st_d.ctl  = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign char_flat = st_q.chr;
    assign cursor_on = st_q.cur;
    assign blank_dis = st_q.bdis;
    assign ctrl      = st_q.ctl;

    // R1: no enable, no change anywhere
    a_r1_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (char_we == '0 && attr_we == '0 && !ctrl_we) |=> $stable(st_q));

    // R6: control word moves only on a digit-0 attribute write
    a_r6_ctrl_kept: assert property (@(posedge clk) disable iff (!clr_n)
        !ctrl_we |=> $stable(st_q.ctl));

    // R5: control fields land from their data bits
    a_r5_ctrl_load: assert property (@(posedge clk) disable iff (!clr_n)
        ctrl_we |=> (st_q.ctl.mblk == $past(data[MBLK_BIT]) &&
                     st_q.ctl.brt  == $past(data[BRT_LSB +: BRT_W]) &&
                     st_q.ctl.efd  == $past(data[EFD_BIT])));

    // R7: state right after clear release is the cleared pattern
    a_r7_cleared: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> (st_q.cur == '0 && st_q.bdis == '0 &&
                          st_q.ctl == '0 &&
                          st_q.chr[0] == DW'(SPACE_CODE) &&
                          st_q.chr[NUM_DIG-1] == DW'(SPACE_CODE)));

endmodule

// File: rtl/disp_wr_port.sv
module disp_wr_port
    import disp_wr_pkg::*;
#(
    parameter  int NUM_DIG = 4,
    parameter  int DW      = 7,
    localparam int AW      = $clog2(NUM_DIG)
) (
    input  logic                  clk,
    input  logic                  clr_n,
    input  logic                  wr_n,
    input  logic                  ce_a_n,
    input  logic                  ce_b_n,
    input  logic                  sel_char,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         din,
    output logic [NUM_DIG*DW-1:0] char_flat,
    output logic [NUM_DIG-1:0]    cursor_on,
    output logic [NUM_DIG-1:0]    blank_dis,
    output logic                  master_blank,
    output logic [BRT_W-1:0]      bright_code,
    output logic                  ext_fn_dis
);

    logic               evt, evt_ce_ok, evt_sel;
    logic [AW-1:0]      evt_addr;
    logic [DW-1:0]      evt_data;
    logic [NUM_DIG-1:0] char_we, attr_we;
    logic               ctrl_we;
    ctrl_t              ctrl;

    disp_wr_sync #(.NUM_DIG(NUM_DIG), .DW(DW)) u_sync (
        .clk       (clk),
        .clr_n     (clr_n),
        .wr_n      (wr_n),
        .ce_a_n    (ce_a_n),
        .ce_b_n    (ce_b_n),
        .sel_char  (sel_char),
        .addr      (addr),
        .din       (din),
        .evt       (evt),
        .evt_ce_ok (evt_ce_ok),
        .evt_sel   (evt_sel),
        .evt_addr  (evt_addr),
        .evt_data  (evt_data)
    );

    disp_wr_decode #(.NUM_DIG(NUM_DIG)) u_dec (
        .clk     (clk),
        .clr_n   (clr_n),
        .evt     (evt),
        .ce_ok   (evt_ce_ok),
        .sel     (evt_sel),
        .addr    (evt_addr),
        .char_we (char_we),
        .attr_we (attr_we),
        .ctrl_we (ctrl_we)
    );

    disp_wr_store #(.NUM_DIG(NUM_DIG), .DW(DW)) u_store (
        .clk       (clk),
        .clr_n     (clr_n),
        .char_we   (char_we),
        .attr_we   (attr_we),
        .ctrl_we   (ctrl_we),
        .data      (evt_data),
        .char_flat (char_flat),
        .cursor_on (cursor_on),
        .blank_dis (blank_dis),
        .ctrl      (ctrl)
    );

    assign master_blank = ctrl.mblk;
    assign bright_code  = ctrl.brt;
    assign ext_fn_dis   = ctrl.efd;

    // R3: an enabled character commit lands in the addressed slot
    a_r3_char_land: assert property (@(posedge clk) disable iff (!clr_n)
        (evt && evt_ce_ok && evt_sel) |=>
            char_flat[$past(evt_addr)*DW +: DW] == $past(evt_data));

    // R4: an enabled attribute commit sets the addressed flags
    a_r4_attr_land: assert property (@(posedge clk) disable iff (!clr_n)
        (evt && evt_ce_ok && !evt_sel) |=>
            (cursor_on[$past(evt_addr)] == $past(evt_data[CUR_BIT]) &&
             blank_dis[$past(evt_addr)] == $past(evt_data[BDIS_BIT])));

endmodule

// File: tb/disp_wr_port_bench.sv
module disp_wr_port_bench;

    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        wr_n = 1'b1;
    logic        ce_a_n = 1'b1;
    logic        ce_b_n = 1'b1;
    logic        sel_char = 1'b0;
    logic [1:0]  addr = '0;
    logic [6:0]  din = '0;
    logic [27:0] char_flat;
    logic [3:0]  cursor_on, blank_dis;
    logic        master_blank, ext_fn_dis;
    logic [2:0]  bright_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    disp_wr_port u_disp_wr_port (
        .clk (clk), .clr_n (clr_n), .wr_n (wr_n), .ce_a_n (ce_a_n),
        .ce_b_n (ce_b_n), .sel_char (sel_char), .addr (addr), .din (din),
        .char_flat (char_flat), .cursor_on (cursor_on), .blank_dis (blank_dis),
        .master_blank (master_blank), .bright_code (bright_code),
        .ext_fn_dis (ext_fn_dis)
    );

    // expected state, built from the requirements
    logic [6:0] m_chr [4];
    logic [3:0] m_cur, m_bd;
    logic       m_mb, m_efd;
    logic [2:0] m_br;

    task automatic model_clear();
        for (int i = 0; i < 4; i++) m_chr[i] = 7'h20;
        m_cur = '0; m_bd = '0; m_mb = 1'b0; m_br = '0; m_efd = 1'b0;
    endtask

    task automatic model_write(input logic ca, input logic cb, input logic s,
                               input logic [1:0] a, input logic [6:0] d);
        if (!ca && !cb) begin
            if (s) m_chr[a] = d;
            else begin
                m_cur[a] = d[0];
                m_bd[a]  = d[1];
                if (a == 2'd0) begin
                    m_mb = d[2]; m_br = d[5:3]; m_efd = d[6];
                end
            end
        end
    endtask

    task automatic check(input string tag);
        logic [27:0] ec;
        logic [40:0] got, exp;
        ec  = {m_chr[3], m_chr[2], m_chr[1], m_chr[0]};
        exp = {ec, m_cur, m_bd, m_mb, m_br, m_efd};
        got = {char_flat, cursor_on, blank_dis, master_blank, bright_code, ext_fn_dis};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // full write cycle; data bus is scrambled after the strobe rises
    task automatic bus_write(input logic ca, input logic cb, input logic s,
                             input logic [1:0] a, input logic [6:0] d);
        @(negedge clk);
        ce_a_n = ca; ce_b_n = cb; sel_char = s; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        din = ~d; addr = ~a; sel_char = ~s; ce_a_n = 1'b1; ce_b_n = 1'b1;
        repeat (2) @(negedge clk);
        model_write(ca, cb, s, a, d);
    endtask

    // {ce_a_n, ce_b_n, sel_char, addr[1:0], din[6:0]}
    localparam logic [11:0] VEC [12] = '{
        {1'b0, 1'b0, 1'b1, 2'd0, 7'h41},
        {1'b0, 1'b0, 1'b1, 2'd3, 7'h5A},
        {1'b0, 1'b0, 1'b1, 2'd1, 7'h31},
        {1'b0, 1'b0, 1'b1, 2'd2, 7'h7F},
        {1'b1, 1'b0, 1'b1, 2'd0, 7'h55},
        {1'b0, 1'b1, 1'b0, 2'd0, 7'h7F},
        {1'b0, 1'b0, 1'b0, 2'd2, 7'h03},
        {1'b0, 1'b0, 1'b0, 2'd0, 7'h6D},
        {1'b0, 1'b0, 1'b0, 2'd3, 7'h7E},
        {1'b0, 1'b0, 1'b1, 2'd0, 7'h00},
        {1'b0, 1'b0, 1'b0, 2'd0, 7'h02},
        {1'b0, 1'b0, 1'b0, 2'd1, 7'h01}
    };

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        check("R7 reset state");

        for (int k = 0; k < 12; k++) begin
            logic [11:0] v;
            string tag;
            v = VEC[k];
            bus_write(v[11], v[10], v[9], v[8:7], v[6:0]);
            if (v[11] || v[10])  tag = "R1 ignored write";
            else if (v[9])       tag = "R3 R9 character write";
            else if (v[8:7] == 0) tag = "R4 R5 control write";
            else                 tag = "R4 R6 attribute write";
            check(tag);
        end

        // R2: held-low strobe, then exact commit latency
        @(negedge clk);
        ce_a_n = 0; ce_b_n = 0; sel_char = 1; addr = 2'd2; din = 7'h33; wr_n = 0;
        repeat (5) @(negedge clk);
        check("R2 no commit while strobe low");
        wr_n = 1'b1;
        @(negedge clk);
        din = 7'h0F;
        check("R2 one edge after rise");
        @(negedge clk);
        m_chr[2] = 7'h33;
        check("R2 committed after second edge");
        ce_a_n = 1; ce_b_n = 1;

        // R7: clear with chip enables inactive
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        model_clear();
        check("R7 clear with enables high");

        // R8: clear hits a write in flight
        @(negedge clk);
        ce_a_n = 0; ce_b_n = 0; sel_char = 1; addr = 2'd1; din = 7'h4B; wr_n = 0;
        @(negedge clk);
        wr_n = 1'b1; clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        check("R8 clear wins over write");
        repeat (4) @(negedge clk);
        check("R8 no late commit");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule